// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block carries out a combined register save or restore with a stack-frame adjustment. It works on an instruction of a compact 16-bit instruction set that has already been fetched. The instruction is either a short 16-bit word or an extended form, which is a 16-bit prefix followed by the 16-bit word. On a start pulse the block decodes the register selection fields and the frame size. It then works through an ordered list of 32-bit word transfers between the register file and memory, one transfer at a time. When the list is finished it writes the new stack pointer and gives a one-cycle done pulse.

The block has a single register-file port, with an address, a combinational read-data return and a write strobe. Memory is reached through a one-word-per-beat port with a valid/ready handshake. Argument registers are stored upward from the incoming stack pointer. All other registers move downward from a pointer that is decremented before each word. A 4-bit argument code selects how many registers count as arguments and how many count as statics, through a table that is not linear.

Top module: `stk_frame_seq`

## Requirements
- R1: The frame size is set as follows. In the short form, frame field `op_word[3:0]` = 0 gives 128 bytes, and any other value n gives n*8 bytes. In the extended form, the size is {`pfx_word[7:4]`, `op_word[3:0]`}*8 bytes.
- R2: A save stores the argument registers upward from the unchanged stack pointer: r4 at +0, r5 at +4, r6 at +8 and r7 at +12. These transfers come first in the list. The number of registers depends on the argument code `pfx_word[3:0]`: 4 for code 14, 3 for codes 12 and 13, 2 for codes 8 to 10, 1 for codes 4 to 7, and 0 for codes 0 to 3 and code 11. A restore never loads these registers.
- R3: The downward list uses a pointer that is decremented by 4 before each word. For a save the pointer starts at the stack pointer, and for a restore it starts at stack pointer + frame size. The order of the list is:
  - r31, if mask bit `op_word[6]` is set;
  - the last N entries of r30, r23, r22, r21, r20, r19, r18, where N is the extra count `pfx_word[10:8]`;
  - r17, if `op_word[4]` is set;
  - r16, if `op_word[5]` is set;
  - the static registers.
- R4: The number of static registers depends on the argument code: 4 for code 11, 3 for codes 3 and 7, 2 for codes 2, 6 and 10, 1 for codes 1, 5, 9 and 13, and 0 for all other valid codes. Static registers move in the order r7, r6, r5, r4.
- R5: `op_word[7]`=1 selects a save and 0 selects a restore. On a save, each memory write carries the read data of the register that `rf_addr` names, and `rf_we` stays low throughout. On a restore, each loaded word is written back to the register named by `rf_addr`, one `rf_we` pulse per word.
- R6: When the list is finished, `sp_we` and `done` pulse together for one cycle. `sp_wdata` is the stack pointer minus the frame size after a save, or the stack pointer plus the frame size after a restore.
- R7: The instruction is rejected in any of these cases:
  - argument code 15;
  - `op_word[15:8]` not equal to 8'h64;
  - in the extended form, `pfx_word[15:11]` not equal to 5'b11110.
  A rejected instruction gives a one-cycle `err` pulse and no memory beat, no `done` and no `sp_we`.
- R8: In the short form (`ext_en`=0), `pfx_word` is ignored, and both the extra count and the argument code are taken as 0.
- R9: Only one beat is outstanding at a time. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` stay unchanged.
- R10: When the transfer list is empty, `done` goes high within two cycles of the start edge.
- R11: A `start` pulse that arrives while `busy` is high is ignored.
- R12: After reset, `busy`, `done`, `err`, `mem_valid`, `rf_we` and `sp_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when idle |
| ext_en | input | 1 | Extended form: `pfx_word` is valid |
| pfx_word | input | 16 | Extension prefix word |
| op_word | input | 16 | Instruction word |
| sp_in | input | AW | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle reject pulse |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | AW | New stack pointer |
| rf_addr | output | RW | Register file index |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | DW | Register file write data |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a store |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Store data |
| mem_ready | input | 1 | Beat accepted |
| mem_rdata | input | DW | Load data, valid with `mem_ready` |

## Verification
The bench sweeps every valid argument code, every extra count and every mask in both directions, then compares each beat's address, register and direction against a list it builds itself. The argument and static tables are non-linear, so a wrong table entry moves registers between the upward run and the tail of the downward run, or drops them; in either case the beat list no longer matches. A frame size of 0 in the short form must give 128 bytes, and restore must start its pointer above the frame. A design that gets either wrong produces addresses and a final stack pointer that are off by whole frames. The bench also drives a stalling ready pattern, tries a restart while busy, sends code 15 and bad opcodes, and times the empty-list case. These tests expose a beat that drifts during a stall, a restart that is accepted, or transfers issued for a rejected word.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int FRW = 11;  // frame size width in bytes, max 2040
  localparam int IW  = 4;   // transfer index width, list length at most 14

  typedef struct packed {
    logic           dir;    // 1 save, 0 restore
    logic [2:0]     mask;   // [2] r31, [1] r16, [0] r17
    logic [2:0]     xs;     // extra saved count
    logic [2:0]     args;   // upward argument count (save only)
    logic [2:0]     stat;   // static count
    logic [IW-1:0]  cnt;    // total transfers
    logic [FRW-1:0] frame;  // frame size in bytes
    logic           bad;    // rejected encoding
  } dec_t;

  typedef enum logic [2:0] {ST_IDLE, ST_PREP, ST_ISSUE, ST_WAIT, ST_SP} st_t;
endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
  import sfs_pkg::*;
(
  input  logic        ext_en,
  input  logic [15:0] pfx_word,
  input  logic [15:0] op_word,
  output dec_t        dec
);
  logic [3:0] code;
  logic [2:0] arg_raw;

  always_comb begin
    code = ext_en ? pfx_word[3:0] : 4'd0;
    dec.dir  = op_word[7];
    dec.mask = op_word[6:4];
    dec.xs   = ext_en ? pfx_word[10:8] : 3'd0;
    dec.frame = ext_en ? {pfx_word[7:4], op_word[3:0], 3'b000}
              : (op_word[3:0] == 4'd0) ? FRW'(128) : {4'd0, op_word[3:0], 3'b000};
    unique case (code)
      4'd4, 4'd5, 4'd6, 4'd7: arg_raw = 3'd1;
      4'd8, 4'd9, 4'd10:      arg_raw = 3'd2;
      4'd12, 4'd13:           arg_raw = 3'd3;
      4'd14:                  arg_raw = 3'd4;
      default:                arg_raw = 3'd0;
    endcase
    unique case (code)
      4'd1, 4'd5, 4'd9, 4'd13: dec.stat = 3'd1;
      4'd2, 4'd6, 4'd10:       dec.stat = 3'd2;
      4'd3, 4'd7:              dec.stat = 3'd3;
      4'd11:                   dec.stat = 3'd4;
      default:                 dec.stat = 3'd0;
    endcase
    dec.args = dec.dir ? arg_raw : 3'd0;
    dec.bad  = (code == 4'd15) || (op_word[15:8] != 8'h64) ||
               (ext_en && (pfx_word[15:11] != 5'b11110));
    dec.cnt  = IW'(dec.args) + IW'(dec.mask[2]) + IW'(dec.mask[1]) +
               IW'(dec.mask[0]) + IW'(dec.xs) + IW'(dec.stat);
  end

  // R2 R4: arguments and statics share the four registers r4..r7
  always_comb begin
    if (!dec.bad) begin
      arg_static_share_chk: assert (arg_raw + dec.stat <= 3'd4);
    end
  end
endmodule

// File: rtl/sfs_pick.sv
module sfs_pick #(
  parameter int RW = 5,
  parameter int IW = 4
) (
  input  logic [IW-1:0] idx,
  input  logic [2:0]    args,
  input  logic [2:0]    mask,
  input  logic [2:0]    xs,
  input  logic [2:0]    stat,
  output logic [RW-1:0] rnum,
  output logic          up
);
  logic [IW-1:0] k;
  logic [IW-1:0] slot;
  logic          hit;

  always_comb begin
    k = idx; hit = 1'b0; up = 1'b0; rnum = '0; slot = '0;
    if (k < IW'(args)) begin
      rnum = RW'(k) + RW'(4); up = 1'b1; hit = 1'b1;
    end else k = k - IW'(args);
    if (!hit && mask[2]) begin
      if (k == '0) begin rnum = RW'(31); hit = 1'b1; end
      else k = k - IW'(1);
    end
    if (!hit) begin
      if (k < IW'(xs)) begin
        slot = IW'(7) - IW'(xs) + k;
        rnum = (slot == '0) ? RW'(30) : RW'(24) - RW'(slot);
        hit  = 1'b1;
      end else k = k - IW'(xs);
    end
    if (!hit && mask[0]) begin
      if (k == '0) begin rnum = RW'(17); hit = 1'b1; end
      else k = k - IW'(1);
    end
    if (!hit && mask[1]) begin
      if (k == '0) begin rnum = RW'(16); hit = 1'b1; end
      else k = k - IW'(1);
    end
    if (!hit && (k < IW'(stat))) begin
      rnum = RW'(7) - RW'(k);
    end
  end
endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
  import sfs_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          ext_en,
  input  logic [15:0]   pfx_word,
  input  logic [15:0]   op_word,
  input  logic [AW-1:0] sp_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          sp_we,
  output logic [AW-1:0] sp_wdata,
  output logic [RW-1:0] rf_addr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [AW-1:0] WORD_B = AW'(4);

  dec_t          dec, dq_q;
  st_t           st_q;
  logic [AW-1:0] sp0_q, ptr_q;
  logic [IW-1:0] idx_q;
  logic [RW-1:0] pick_r;
  logic          pick_up;

  sfs_decode u_dec (.ext_en(ext_en), .pfx_word(pfx_word), .op_word(op_word), .dec(dec));

  sfs_pick #(.RW(RW), .IW(IW)) u_pick (
    .idx(idx_q), .args(dq_q.args), .mask(dq_q.mask), .xs(dq_q.xs),
    .stat(dq_q.stat), .rnum(pick_r), .up(pick_up)
  );

  assign busy = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; dq_q <= '0; sp0_q <= '0; ptr_q <= '0; idx_q <= '0;
      done <= 1'b0; err <= 1'b0; sp_we <= 1'b0; sp_wdata <= '0;
      rf_addr <= '0; rf_we <= 1'b0; rf_wdata <= '0;
      mem_valid <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      done <= 1'b0; err <= 1'b0; sp_we <= 1'b0; rf_we <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (dec.bad) err <= 1'b1;
          else begin
            dq_q  <= dec;
            sp0_q <= sp_in;
            ptr_q <= dec.dir ? sp_in : sp_in + AW'(dec.frame);
            idx_q <= '0;
            st_q  <= (dec.cnt == '0) ? ST_SP : ST_PREP;
          end
        end
        ST_PREP: begin
          rf_addr <= pick_r;
          mem_we  <= dq_q.dir;
          if (pick_up) mem_addr <= sp0_q + AW'({idx_q, 2'b00});
          else begin
            mem_addr <= ptr_q - WORD_B;
            ptr_q    <= ptr_q - WORD_B;
          end
          st_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          mem_wdata <= rf_rdata;
          mem_valid <= 1'b1;
          st_q      <= ST_WAIT;
        end
        ST_WAIT: if (mem_ready) begin
          mem_valid <= 1'b0;
          if (!dq_q.dir) begin
            rf_we    <= 1'b1;
            rf_wdata <= mem_rdata;
          end
          idx_q <= idx_q + IW'(1);
          st_q  <= (idx_q + IW'(1) == dq_q.cnt) ? ST_SP : ST_PREP;
        end
        ST_SP: begin
          sp_we    <= 1'b1;
          sp_wdata <= dq_q.dir ? sp0_q - AW'(dq_q.frame) : sp0_q + AW'(dq_q.frame);
          done     <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));
  // R9
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_with_sp_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> sp_we && !busy);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy && !mem_valid && !done && !sp_we);
  // R7
  no_bad_run_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dq_q.bad);
  // R5
  save_no_rf_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !mem_we && !mem_valid);
endmodule

// File: tb/test_stk_frame_seq.sv
module test_stk_frame_seq;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, ext_en = 1'b0;
  logic [15:0] pfx_word = '0, op_word = '0;
  logic [31:0] sp_in = '0;
  logic        busy, done, err, sp_we, rf_we, mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [31:0] sp_wdata, rf_wdata, mem_addr, mem_wdata, rf_rdata, mem_rdata;
  logic [4:0]  rf_addr;

  localparam logic [31:0] MKEY = 32'h5A5A_0000;

  always #4 clk = ~clk;

  assign rf_rdata  = 32'hC0DE_0000 | 32'(rf_addr);
  assign mem_rdata = mem_addr ^ MKEY;

  stk_frame_seq i_stk_frame_seq (
    .clk(clk), .rst(rst), .start(start), .ext_en(ext_en), .pfx_word(pfx_word),
    .op_word(op_word), .sp_in(sp_in), .busy(busy), .done(done), .err(err),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  int n_run = 0, n_fail = 0;
  int cycles = 0;

  // expected list
  int e_n; int e_addr[16]; int e_reg[16]; logic [31:0] e_sp; bit e_bad; bit e_dir;
  // observed
  bit rec = 0;
  int o_n, w_n, d_n, s_n, x_n, h_bad;
  logic [31:0] o_addr[16], o_wd[16], w_d[16], s_val, p_addr, p_wd;
  int o_reg[16], w_reg[16]; bit o_we[16];
  bit p_stall;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int acnt(int c);
    if (c == 14) return 4;
    if (c == 12 || c == 13) return 3;
    if (c >= 8 && c <= 10) return 2;
    if (c >= 4 && c <= 7) return 1;
    return 0;
  endfunction

  function automatic int scnt(int c);
    if (c == 11) return 4;
    if (c == 3 || c == 7) return 3;
    if (c == 2 || c == 6 || c == 10) return 2;
    if (c == 1 || c == 5 || c == 9 || c == 13) return 1;
    return 0;
  endfunction

  task automatic calc(bit ext, logic [15:0] pf, logic [15:0] op, logic [31:0] sp);
    int code, xs, fr, p, na;
    code = ext ? int'(pf[3:0]) : 0;
    xs   = ext ? int'(pf[10:8]) : 0;
    e_dir = op[7];
    fr = ext ? int'({pf[7:4], op[3:0]}) * 8 : (op[3:0] == 0 ? 128 : int'(op[3:0]) * 8);
    e_bad = (code == 15) || (op[15:8] != 8'h64) || (ext && pf[15:11] != 5'b11110);
    e_n = 0;
    na = e_dir ? acnt(code) : 0;
    for (int i = 0; i < na; i++) begin e_reg[e_n] = 4 + i; e_addr[e_n] = int'(sp) + 4 * i; e_n++; end
    p = e_dir ? int'(sp) : int'(sp) + fr;
    if (op[6]) begin p -= 4; e_reg[e_n] = 31; e_addr[e_n] = p; e_n++; end
    for (int i = 0; i < xs; i++) begin
      int s;
      s = 7 - xs + i;
      p -= 4; e_reg[e_n] = (s == 0) ? 30 : 24 - s; e_addr[e_n] = p; e_n++;
    end
    if (op[4]) begin p -= 4; e_reg[e_n] = 17; e_addr[e_n] = p; e_n++; end
    if (op[5]) begin p -= 4; e_reg[e_n] = 16; e_addr[e_n] = p; e_n++; end
    for (int i = 0; i < scnt(code); i++) begin p -= 4; e_reg[e_n] = 7 - i; e_addr[e_n] = p; e_n++; end
    e_sp = e_dir ? sp - 32'(fr) : sp + 32'(fr);
  endtask

  // monitor, samples at the falling edge
  initial forever begin
    @(negedge clk);
    if (rec) begin
      if (p_stall && (!mem_valid || mem_addr != p_addr || mem_wdata != p_wd)) h_bad++;
      p_stall = mem_valid && !mem_ready;
      p_addr = mem_addr; p_wd = mem_wdata;
      if (mem_valid && mem_ready && o_n < 16) begin
        o_addr[o_n] = mem_addr; o_reg[o_n] = int'(rf_addr); o_we[o_n] = mem_we;
        o_wd[o_n] = mem_wdata; o_n++;
      end
      if (rf_we && w_n < 16) begin w_reg[w_n] = int'(rf_addr); w_d[w_n] = rf_wdata; w_n++; end
      if (done) d_n++;
      if (sp_we) begin s_n++; s_val = sp_wdata; end
      if (err) x_n++;
    end
  end

  // ready pattern with stalls, changed shortly after the rising edge
  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    forever begin
      @(posedge clk); #2;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_ready = lf[0] | lf[5];
    end
  end

  task automatic run_op(string tag, bit ext, logic [15:0] pf, logic [15:0] op,
                        logic [31:0] sp, bit dbl);
    int cyc;
    bit bad_list, bad_data;
    calc(ext, pf, op, sp);
    o_n = 0; w_n = 0; d_n = 0; s_n = 0; x_n = 0; h_bad = 0; p_stall = 0;
    rec = 1;
    @(negedge clk);
    ext_en = ext; pfx_word = pf; op_word = op; sp_in = sp; start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      start = dbl && (cyc == 3);
      if (start) op_word = 16'h64F0;
    end while (!(done || err) && cyc < 400);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rec = 0;
    if (e_bad) begin
      chk(x_n == 1, "R7", {tag, " err pulses"}, 32'(x_n), 1);
      chk(o_n == 0 && d_n == 0 && s_n == 0, "R7", {tag, " activity on reject"},
          32'(o_n + d_n + s_n), 0);
      return;
    end
    chk(o_n == e_n, "R3", {tag, " beat count"}, 32'(o_n), 32'(e_n));
    bad_list = 0; bad_data = 0;
    for (int i = 0; i < e_n && i < o_n; i++) begin
      if (o_addr[i] != 32'(e_addr[i]) || o_reg[i] != e_reg[i] || o_we[i] != e_dir) bad_list = 1;
      if (e_dir && o_wd[i] != (32'hC0DE_0000 | 32'(e_reg[i]))) bad_data = 1;
      if (!e_dir && (i >= w_n || w_reg[i] != e_reg[i] || w_d[i] != (32'(e_addr[i]) ^ MKEY)))
        bad_data = 1;
    end
    chk(!bad_list, "R2 R3 R4", {tag, " beat list"}, o_n > 0 ? o_addr[0] : 0,
        e_n > 0 ? 32'(e_addr[0]) : 0);
    chk(!bad_data && (e_dir ? w_n == 0 : w_n == e_n), "R5", {tag, " data movement"},
        32'(w_n), e_dir ? 0 : 32'(e_n));
    chk(s_n == 1 && s_val == e_sp, "R6 R1", {tag, " new stack pointer"}, s_val, e_sp);
    chk(d_n == 1, "R6", {tag, " done pulses"}, 32'(d_n), 1);
    chk(h_bad == 0, "R9", {tag, " beat held during stall"}, 32'(h_bad), 0);
    if (e_n == 0) chk(cyc <= 2, "R10", {tag, " empty list latency"}, 32'(cyc), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !err && !mem_valid && !rf_we && !sp_we, "R12", "reset outputs",
        {26'd0, busy, done, err, mem_valid, rf_we, sp_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R1 R8: short form sweep with a garbage prefix
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 8; m++)
        for (int f = 0; f < 16; f++)
          run_op("R8 short", 1'b0, 16'hFFFF,
                 {8'h64, 1'(d), 3'(m), 4'(f)}, 32'h0000_8000 + 32'(f * 64), 1'b0);
    // R2 R3 R4: extended form sweep
    for (int d = 0; d < 2; d++)
      for (int x = 0; x < 8; x++)
        for (int c = 0; c < 15; c++)
          for (int m = 0; m < 8; m++)
            run_op("ext", 1'b1, {5'b11110, 3'(x), 4'(x + c), 4'(c)},
                   {8'h64, 1'(d), 3'(m), 4'(m * 3 + c)},
                   32'h0001_0000 + 32'(c * 256 + x * 16), 1'b0);
    // R7 rejects
    run_op("R7 code15 save", 1'b1, 16'hF20F, 16'h64F1, 32'h2000, 1'b0);
    run_op("R7 code15 rest", 1'b1, 16'hF70F, 16'h6475, 32'h2000, 1'b0);
    run_op("R7 bad op", 1'b0, 16'h0000, 16'h65F1, 32'h2000, 1'b0);
    run_op("R7 bad pfx", 1'b1, 16'hE00E, 16'h64F1, 32'h2000, 1'b0);
    // R10 empty lists
    run_op("R10 short", 1'b0, 16'h0000, 16'h6485, 32'h3000, 1'b0);
    run_op("R10 ext", 1'b1, 16'hF000, 16'h6400, 32'h3000, 1'b0);
    // R11 restart while busy
    run_op("R11 save", 1'b1, 16'hF73E, 16'h64F2, 32'h4000, 1'b1);
    run_op("R11 rest", 1'b1, 16'hF5A3, 16'h6474, 32'h4400, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // watchdog
  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule